// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution unit of a small processor core. It takes two 32-bit operands and a 5-bit operation code. It produces a 32-bit result and a write enable for the destination register, in the same cycle. It also keeps a four-bit status register holding the negative (N), zero (Z), carry (C) and overflow (V) flags. The add-with-carry, subtract-with-carry and rotate-with-extend operations read the stored carry, so a multi-word sum or difference can be built from a chain of single-cycle operations.

The operations fall into five groups: arithmetic, bitwise logic, moves, compare/test and shifts. A `set_flags` input chooses whether an ordinary operation updates the status register. Compare and test operations always update the flags and never request a register write. The combinational `nzcv_next` output shows the value the status register will take at the next rising clock edge. This lets a downstream condition check see the flags one cycle early.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcodes 0..4 are ADD (a+b), ADC (a+b+C), SUB (a-b), SBC (a-b-1+C) and RSB (b-a), and each asserts `wr_en`. With flags enabled: N = result bit 31, Z = (result == 0), C = carry out of the addition (for subtractions, C = 1 when no borrow occurs), and V = two's-complement overflow.
- R2: ADC and SBC take their carry-in from the stored C flag, so ADD followed by ADC, both with `set_flags` high, yields the correct 64-bit sum.
- R3: Opcodes 5..9 are AND, ORR (a|b), EOR (a^b), BIC (a & ~b) and ORN (a | ~b), each with `wr_en` high. With flags enabled they set N and Z from the result and leave C and V unchanged.
- R4: Opcode 10 (MOV) outputs b and opcode 11 (MVN) outputs ~b; with flags enabled these set N and Z and keep C and V. Opcode 12 (MOVT) outputs {b[15:0], a[15:0]} and never changes the flags.
- R5: Opcode 13 (CMP, a-b) and opcode 14 (CMN, a+b) hold `wr_en` low and update all four flags as in R1, whatever the value of `set_flags`.
- R6: Opcode 15 (TST, a&b) and opcode 16 (TEQ, a^b) hold `wr_en` low, always update N and Z, and leave C and V unchanged.
- R7: Opcodes 17..20 are ASR, LSL, LSR and ROR of a, by the amount in b[7:0]. An amount of 0 passes a through and keeps C. Otherwise C is the last bit shifted out. LSL or LSR by exactly 32 gives 0, with C equal to a[0] or a[31] respectively, and by more than 32 gives 0 with C=0. ASR by 32 or more fills with a[31] and sets C=a[31]. ROR by a nonzero multiple of 32 gives a, with C=a[31]. With flags enabled, shifts set N, Z and C and keep V.
- R8: Opcode 21 (RRX) outputs {C, a[31:1]} and, with flags enabled, moves a[0] into C.
- R9: When `set_flags` is low and the opcode is not a compare or test, `nzcv_next` equals `nzcv` and the status register keeps its value.
- R10: Opcodes 22..31 are undefined: `result` is 0, `wr_en` is low and the flags do not change.
- R11: While `rst` is high at a rising edge, the status register clears to 0000.
- R12: After each rising edge with `rst` low, `nzcv` equals the `nzcv_next` value that was present before that edge. The flags are packed as {N,Z,C,V}, with N in bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op_sel | input | 5 | Operation code |
| set_flags | input | 1 | Enables flag update for non-compare operations |
| opa | input | 32 | First operand (current destination value for MOVT) |
| opb | input | 32 | Second operand, shift amount in bits 7:0 |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write request |
| nzcv_next | output | 4 | Flags after the next edge, {N,Z,C,V} |
| nzcv | output | 4 | Stored flags, {N,Z,C,V} |

## Verification
The only state in the block is the four flag bits. A wrong stored carry therefore shows up on the very next ADC, SBC or RRX result, and a wrong update decision shows up on `nzcv` one edge later. Random operation sequences keep a flag model running alongside the design, so a bad flag is detected at the first dependent operation rather than at the end of a sequence. Directed cases pin down the boundaries where the shift amount reaches 0, 32 and 33, and the cases where signed overflow and borrow occur.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN = 32;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_RSB  = 5'd4,
        OP_AND  = 5'd5,
        OP_ORR  = 5'd6,
        OP_EOR  = 5'd7,
        OP_BIC  = 5'd8,
        OP_ORN  = 5'd9,
        OP_MOV  = 5'd10,
        OP_MVN  = 5'd11,
        OP_MOVT = 5'd12,
        OP_CMP  = 5'd13,
        OP_CMN  = 5'd14,
        OP_TST  = 5'd15,
        OP_TEQ  = 5'd16,
        OP_ASR  = 5'd17,
        OP_LSL  = 5'd18,
        OP_LSR  = 5'd19,
        OP_ROR  = 5'd20,
        OP_RRX  = 5'd21
    } alu_op_e;

    localparam logic [4:0] OP_LAST = 5'd21;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_defined(logic [4:0] code);
        return code <= OP_LAST;
    endfunction

    function automatic logic op_flag_only(logic [4:0] code);
        return (code >= OP_CMP) && (code <= OP_TEQ);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           ovf
);
    logic [W-1:0] x, y;
    logic         ci;
    logic [W:0]   sum;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        case (op)
            OP_ADC:         ci = cin;
            OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
            OP_SBC:         begin y = ~b; ci = cin;  end
            OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
            default:        ci = 1'b0;
        endcase
        sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        res  = sum[W-1:0];
        cout = sum[W];
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    localparam int H = W / 2;

    always_comb begin
        case (op)
            OP_AND, OP_TST: res = a & b;
            OP_ORR:         res = a | b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_BIC:         res = a & ~b;
            OP_ORN:         res = a | ~b;
            OP_MOV:         res = b;
            OP_MVN:         res = ~b;
            OP_MOVT:        res = {b[H-1:0], a[H-1:0]};
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [7:0]     amt,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int SW = $clog2(W);
    localparam logic [SW:0] WBITS = (SW+1)'(W);
    localparam logic [7:0]  WAMT  = 8'(W);

    logic [W:0]    tl, tr, ta;
    logic [SW-1:0] rot;
    logic [SW:0]   back;
    logic [W-1:0]  rr;

    always_comb begin
        tl   = {1'b0, a} << amt;
        tr   = {a, 1'b0} >> amt;
        ta   = $unsigned($signed({a, 1'b0}) >>> amt);
        rot  = amt[SW-1:0];
        back = WBITS - {1'b0, rot};
        rr   = (a >> rot) | (a << back);
        res  = a;
        cout = cin;
        case (op)
            OP_LSL: if (amt != 8'd0) begin
                if (amt <= WAMT) begin res = tl[W-1:0]; cout = tl[W]; end
                else             begin res = '0;        cout = 1'b0;  end
            end
            OP_LSR: if (amt != 8'd0) begin
                res  = tr[W:1];
                cout = tr[0];
            end
            OP_ASR: if (amt != 8'd0) begin
                if (amt >= WAMT) begin res = {W{a[W-1]}}; cout = a[W-1]; end
                else             begin res = ta[W:1];     cout = ta[0];  end
            end
            OP_ROR: if (amt != 8'd0) begin
                res  = rr;
                cout = rr[W-1];
            end
            OP_RRX: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            default: begin res = a; cout = cin; end
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [4:0]     op_sel,
    input  logic           set_flags,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   result,
    output logic           wr_en,
    output logic [3:0]     nzcv_next,
    output logic [3:0]     nzcv
);
    localparam int H = W / 2;

    alu_op_e      op;
    nzcv_t        flags_q, flags_d, cand;
    logic         upd;
    logic [W-1:0] ar, lr, sr;
    logic         ac, av, sc;

    assign op = alu_op_e'(op_sel);

    alu_arith #(.W(W)) u_arith (
        .op(op), .a(opa), .b(opb), .cin(flags_q.c),
        .res(ar), .cout(ac), .ovf(av)
    );

    alu_logic #(.W(W)) u_logic (
        .op(op), .a(opa), .b(opb), .res(lr)
    );

    alu_shift #(.W(W)) u_shift (
        .op(op), .a(opa), .amt(opb[7:0]), .cin(flags_q.c),
        .res(sr), .cout(sc)
    );

    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        upd    = 1'b0;
        cand   = flags_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB: begin
                result = ar; wr_en = 1'b1; upd = set_flags;
                cand   = '{n: ar[W-1], z: (ar == '0), c: ac, v: av};
            end
            OP_CMP, OP_CMN: begin
                result = ar; upd = 1'b1;
                cand   = '{n: ar[W-1], z: (ar == '0), c: ac, v: av};
            end
            OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_ORN, OP_MOV, OP_MVN: begin
                result = lr; wr_en = 1'b1; upd = set_flags;
                cand   = '{n: lr[W-1], z: (lr == '0), c: flags_q.c, v: flags_q.v};
            end
            OP_TST, OP_TEQ: begin
                result = lr; upd = 1'b1;
                cand   = '{n: lr[W-1], z: (lr == '0), c: flags_q.c, v: flags_q.v};
            end
            OP_MOVT: begin
                result = lr; wr_en = 1'b1;
            end
            OP_ASR, OP_LSL, OP_LSR, OP_ROR, OP_RRX: begin
                result = sr; wr_en = 1'b1; upd = set_flags;
                cand   = '{n: sr[W-1], z: (sr == '0), c: sc, v: flags_q.v};
            end
            default: begin
                result = '0; wr_en = 1'b0; upd = 1'b0;
            end
        endcase
        flags_d = upd ? cand : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign nzcv_next = flags_d;
    assign nzcv      = flags_q;

    assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_CMP || op_sel == OP_CMN) |-> !wr_en);

    assert_tst_keeps_cv_R6: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_TST || op_sel == OP_TEQ) |-> (!wr_en && nzcv_next[1:0] == nzcv[1:0]));

    assert_hold_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (!set_flags && !op_flag_only(op_sel)) |=> $stable(nzcv));

    assert_undef_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !op_defined(op_sel) |-> (!wr_en && result == '0 && nzcv_next == nzcv));

    assert_movt_low_R4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_MOVT) |-> (result[H-1:0] == opa[H-1:0] && nzcv_next == nzcv));

    assert_reg_follows_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (nzcv == $past(nzcv_next)));

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = '0;
    logic        set_flags = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  nzcv_next;
    logic [3:0]  nzcv;

    int total = 0;
    int bad   = 0;
    logic [3:0] mflags = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_unit dut_i (
        .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags),
        .opa(opa), .opb(opb), .result(result), .wr_en(wr_en),
        .nzcv_next(nzcv_next), .nzcv(nzcv)
    );

    function automatic string req_of(int op, logic sf);
        if (op > 21) return "R10";
        if (op == 13 || op == 14) return "R5";
        if (op == 15 || op == 16) return "R6";
        if (op == 12) return "R4";
        if (!sf) return "R9";
        if (op == 1 || op == 3) return "R2";
        if (op <= 4) return "R1";
        if (op <= 9) return "R3";
        if (op <= 11) return "R4";
        if (op == 21) return "R8";
        return "R7";
    endfunction

    // returns {wr, result, flags_next}
    function automatic logic [36:0] model(int op, logic [31:0] a, logic [31:0] b,
                                          logic sf, logic [3:0] f);
        logic [31:0] r = '0;
        logic wr = 1'b0, upd = 1'b0, c = f[1], v = f[0], keepcv = 1'b0;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint sr;
        logic [63:0] ua = {32'd0, a};
        logic [63:0] ub = {32'd0, b};
        logic [63:0] us;
        int n = int'(b[7:0]);
        logic [31:0] x;
        case (op)
            0, 1, 14: begin
                us = ua + ub + ((op == 1) ? 64'(f[1]) : 64'd0);
                sr = sa + sb + ((op == 1) ? longint'(f[1]) : 0);
                r = us[31:0]; c = us[32];
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                wr = (op != 14); upd = (op == 14) || sf;
            end
            2, 3, 13, 4: begin
                longint bw = (op == 3) ? longint'(!f[1]) : 0;
                if (op == 4) begin
                    r = b - a; c = (b >= a); sr = sb - sa;
                end else begin
                    r = a - b - 32'(bw);
                    c = (ua >= ub + 64'(bw)); sr = sa - sb - bw;
                end
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                wr = (op != 13); upd = (op == 13) || sf;
            end
            5, 15: begin r = a & b;  keepcv = 1; wr = (op == 5); upd = (op == 15) || sf; end
            6:     begin r = a | b;  keepcv = 1; wr = 1; upd = sf; end
            7, 16: begin r = a ^ b;  keepcv = 1; wr = (op == 7); upd = (op == 16) || sf; end
            8:     begin r = a & ~b; keepcv = 1; wr = 1; upd = sf; end
            9:     begin r = a | ~b; keepcv = 1; wr = 1; upd = sf; end
            10:    begin r = b;      keepcv = 1; wr = 1; upd = sf; end
            11:    begin r = ~b;     keepcv = 1; wr = 1; upd = sf; end
            12:    begin r = {b[15:0], a[15:0]}; wr = 1; upd = 0; end
            17, 18, 19, 20, 21: begin
                x = a;
                if (op == 21) begin
                    x = {f[1], a[31:1]}; c = a[0];
                end else if (n != 0) begin
                    int reps = (op == 20) ? ((n % 32 == 0) ? 32 : n % 32)
                                          : ((n > 33) ? 33 : n);
                    for (int i = 0; i < reps; i++) begin
                        case (op)
                            17: begin c = x[0];  x = {x[31], x[31:1]}; end
                            18: begin c = x[31]; x = {x[30:0], 1'b0}; end
                            19: begin c = x[0];  x = {1'b0, x[31:1]}; end
                            default: begin x = {x[0], x[31:1]}; c = x[31]; end
                        endcase
                    end
                end
                r = x; wr = 1; upd = sf;
            end
            default: begin r = '0; wr = 0; upd = 0; end
        endcase
        if (keepcv) begin c = f[1]; v = f[0]; end
        if (op >= 17 && op <= 21) v = f[0];
        return {wr, r, upd ? {r[31], (r == 0), c, v} : f};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(int op, logic [31:0] a, logic [31:0] b, logic sf);
        logic [36:0] e;
        string tag;
        @(negedge clk);
        op_sel = 5'(op); opa = a; opb = b; set_flags = sf;
        #1;
        e = model(op, a, b, sf, mflags);
        tag = req_of(op, sf);
        check(tag, "wr_en", 32'(wr_en), 32'(e[36]));
        if (e[36] || op > 21) check(tag, "result", result, e[35:4]);
        check(tag, "nzcv_next", 32'(nzcv_next), 32'(e[3:0]));
        @(posedge clk);
        #1;
        mflags = e[3:0];
        check("R12", "nzcv", 32'(nzcv), 32'(mflags));
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'(int'($urandom_range(0, 40)));
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset nzcv", 32'(nzcv), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        run_op(0, 32'h7FFF_FFFF, 32'h1, 1);            // R1 signed overflow
        run_op(2, 32'h1234, 32'h1234, 1);              // R1 Z and no borrow
        run_op(2, 32'h0, 32'h1, 1);                    // R1 borrow
        run_op(4, 32'h10, 32'h500, 1);                 // R1 reverse subtract
        run_op(0, 32'hFFFF_FFFF, 32'h1, 1);            // R2 low word carry
        run_op(1, 32'h0, 32'h0, 1);                    // R2 high word gets carry
        run_op(2, 32'h0, 32'h1, 1);                    // borrow -> C=0
        run_op(3, 32'h5, 32'h2, 1);                    // R2 sbc with borrow
        run_op(8, 32'hFFFF_FFFF, 32'h0F0F_0000, 1);    // R3 BIC
        run_op(9, 32'h0, 32'hFFFF_FFF0, 1);            // R3 ORN
        run_op(12, 32'hAAAA_5555, 32'h0000_F0F0, 1);   // R4 MOVT
        run_op(11, 32'h0, 32'h0, 1);                   // R4 MVN
        run_op(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1);    // set V
        run_op(15, 32'hF0, 32'h0F, 0);                 // R6 TST keeps V
        run_op(16, 32'h5, 32'h5, 0);                   // R6 TEQ equal
        run_op(13, 32'h3, 32'h3, 0);                   // R5 CMP with set_flags low
        run_op(14, 32'hFFFF_FFFF, 32'h1, 0);           // R5 CMN
        run_op(0, 32'h8000_0000, 32'h8000_0000, 0);    // R9 no update
        run_op(18, 32'h8000_0001, 32'd0, 1);           // R7 amount 0
        run_op(18, 32'h0000_0001, 32'd32, 1);          // R7 LSL 32
        run_op(18, 32'hFFFF_FFFF, 32'd33, 1);          // R7 LSL 33
        run_op(19, 32'h8000_0000, 32'd32, 1);          // R7 LSR 32
        run_op(17, 32'h8000_0000, 32'd40, 1);          // R7 ASR big
        run_op(20, 32'h8000_0001, 32'd32, 1);          // R7 ROR 32
        run_op(20, 32'h0000_0003, 32'd1, 1);           // R7 ROR 1
        run_op(21, 32'h0000_0001, 32'h0, 1);           // R8 RRX
        run_op(21, 32'h0000_0002, 32'h0, 1);           // R8 carry in
        run_op(22, 32'hFFFF_FFFF, 32'h1, 1);           // R10
        run_op(31, 32'h1, 32'h1, 1);                   // R10

        for (int k = 0; k < 400; k++) begin
            int op = int'($urandom_range(0, 31));
            logic [31:0] a = pick();
            logic [31:0] b = pick();
            run_op(op, a, b, 1'($urandom_range(0, 1)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule